// File: doc/BRIEF.md
# Coherence Message Event Classifier

This block sits in front of a private mid-level cache controller's state machine. Three message queues present their heads to it at once. The first carries responses from the outer level, the second carries requests forwarded by the outer level, and the third carries requests and acknowledgements from the inner cache. Alongside each head the cache supplies a lookup result. For a response this is the line state and the outstanding-ack count. For a forwarded request it is the line's presence and state. For an inner request it is hit, free-way and victim information. In each cycle the classifier picks one queue and names the coherence event the state machine must handle. It also gives the address that event applies to.

The event, queue and address outputs are combinational from the queue heads. The consumer answers in the same cycle with a stall signal. An event that is accepted pulses the dequeue strobe of its queue. An event that is stalled leaves the message in place and parks its queue under the event's address. A parked queue is passed over, so lower-priority queues keep moving, until a wake pulse for that address arrives.

Top module: `coh_event_classifier`

## Requirements
- R1: At most one event is chosen per cycle. Priority, highest first, is responses (source code 0), then forwarded requests (1), then inner requests (2), counting only queues that are valid and not parked. The chosen queue's dequeue strobe rises only when its event is accepted (no stall) or is dropped as an error. No other strobe rises.
- R2: Response type 0 (exclusive data) gives event 12. Type 1 (data) gives event 13 when the line state is 7 (read miss pending) and the sender is a peer cache. Otherwise type 1 gives event 14 when the pending-ack count equals the message's ack count, and event 15 when it does not. The event address is the message address.
- R3: Response type 2 (ack) gives event 16 when the pending-ack count equals the message's ack count, and event 17 otherwise. Type 3 (writeback ack) gives event 18.
- R4: Forwarded types are 0 invalidate, 1 exclusive read, 2 upgrade and 3 shared read. Any of them gives event 7 (invalidate the inner copy for another requester) when the line is valid and its state is one the inner cache may hold: 1, 3, 5, 12, 13, 14 or 16. Otherwise they give event 9 (invalidate), 10 (exclusive forward, for types 1 and 2) or 11 (shared forward).
- R5: Inner type 4 (invalidate with data) gives event 4 and type 5 (invalidate ack) gives event 5. For types 0 (load), 1 (store), 2 (upgrade) and 3 (writeback), a line hit or a free way gives event 1, 2, 2 and 3 respectively, at the request address.
- R6: An inner request of types 0 to 3 that misses with no free way targets the victim address. It gives event 6 (invalidate the inner copy for own eviction) when the victim is valid in a state the inner cache may hold, and event 8 (eviction) otherwise.
- R7: Unknown types are response 4 to 7, forwarded 4 to 7 and inner 6 to 7. When the chosen head has an unknown type, the error flag rises and no event is presented. The message is dequeued regardless of stall. Whenever no event is presented, event code, source and address read 0.
- R8: A stalled event does not dequeue. Its queue is parked from the next cycle under the event address, and arbitration passes over it.
- R9: A wake pulse releases, from the next cycle, every parked queue whose address equals the wake address. It leaves other parked queues parked.
- R10: After reset no queue is parked. With no valid head the block presents no event and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rsp_vld_i | input | 1 | Response head valid |
| rsp_type_i | input | 3 | Response type |
| rsp_addr_i | input | ADDR_W | Response line address |
| rsp_ack_cnt_i | input | ACK_W | Ack count carried by the response |
| rsp_from_peer_i | input | 1 | Response was sent by a peer cache |
| rsp_line_state_i | input | 5 | Line state for the response address |
| rsp_pend_acks_i | input | ACK_W | Outstanding acks for the response address |
| fwd_vld_i | input | 1 | Forwarded request head valid |
| fwd_type_i | input | 3 | Forwarded request type |
| fwd_addr_i | input | ADDR_W | Forwarded request address |
| fwd_line_vld_i | input | 1 | Line present for the forwarded address |
| fwd_line_state_i | input | 5 | Line state for the forwarded address |
| inr_vld_i | input | 1 | Inner request head valid |
| inr_type_i | input | 3 | Inner request type |
| inr_addr_i | input | ADDR_W | Inner request address |
| inr_line_vld_i | input | 1 | Inner request hits a line |
| inr_way_free_i | input | 1 | A free way exists in the set |
| vic_addr_i | input | ADDR_W | Victim line address |
| vic_line_vld_i | input | 1 | Victim line valid |
| vic_line_state_i | input | 5 | Victim line state |
| evt_stall_i | input | 1 | Consumer cannot take the presented event |
| wake_i | input | 1 | Wake pulse |
| wake_addr_i | input | ADDR_W | Address being woken |
| evt_vld_o | output | 1 | Event presented |
| evt_src_o | output | 2 | Source queue of the event |
| evt_code_o | output | 5 | Event code |
| evt_addr_o | output | ADDR_W | Event target address |
| rsp_deq_o | output | 1 | Dequeue response head |
| fwd_deq_o | output | 1 | Dequeue forwarded head |
| inr_deq_o | output | 1 | Dequeue inner head |
| err_o | output | 1 | Unknown message type dropped |

## Verification
Some properties are checked by the assertions on every cycle. Only one strobe may rise at a time, and a valid unparked response blocks the other queues. An error never coexists with an event, and a stalled or parked queue never dequeues. Forwarded requests to inner-held lines always redirect, and eviction events carry the victim address. The per-type event mapping and the ack-count comparisons can only be shown by the bench's scenarios. So can the choice between a peer-sourced and a directory-sourced fill, and the release of a parked queue by a matching wake while a non-matching wake leaves it parked.

// File: rtl/coh_evt_pkg.sv
package coh_evt_pkg;

    typedef enum logic [4:0] {
        ST_I      = 5'd0,
        ST_S      = 5'd1,
        ST_SS     = 5'd2,
        ST_E      = 5'd3,
        ST_EE     = 5'd4,
        ST_M      = 5'd5,
        ST_MM     = 5'd6,
        ST_IS     = 5'd7,
        ST_IM     = 5'd8,
        ST_SM     = 5'd9,
        ST_MI     = 5'd10,
        ST_SINK   = 5'd11,
        ST_S_IV   = 5'd12,
        ST_E_IV   = 5'd13,
        ST_M_IV   = 5'd14,
        ST_MM_IV  = 5'd15,
        ST_SM_IV  = 5'd16
    } line_st_e;

    typedef enum logic [4:0] {
        EV_NONE          = 5'd0,
        EV_LOAD          = 5'd1,
        EV_STORE         = 5'd2,
        EV_WRITEBACK     = 5'd3,
        EV_INR_DATA_ACK  = 5'd4,
        EV_INR_ACK       = 5'd5,
        EV_INR_INV_OWN   = 5'd6,
        EV_INR_INV_OTHER = 5'd7,
        EV_EVICT         = 5'd8,
        EV_INV           = 5'd9,
        EV_FWD_EXCL      = 5'd10,
        EV_FWD_SHARED    = 5'd11,
        EV_DATA_EXCL     = 5'd12,
        EV_DATA_PEER     = 5'd13,
        EV_DATA_ALL      = 5'd14,
        EV_DATA          = 5'd15,
        EV_ACK_ALL       = 5'd16,
        EV_ACK           = 5'd17,
        EV_WB_ACK        = 5'd18
    } evt_e;

    typedef enum logic [1:0] {
        SRC_RSP = 2'd0,
        SRC_FWD = 2'd1,
        SRC_INR = 2'd2
    } src_e;

    localparam int NUM_Q = 3;

    localparam logic [2:0] RSP_T_DATA_EXCL = 3'd0;
    localparam logic [2:0] RSP_T_DATA      = 3'd1;
    localparam logic [2:0] RSP_T_ACK       = 3'd2;
    localparam logic [2:0] RSP_T_WB_ACK    = 3'd3;

    localparam logic [2:0] FWD_T_INV       = 3'd0;
    localparam logic [2:0] FWD_T_GETX      = 3'd1;
    localparam logic [2:0] FWD_T_UPGRADE   = 3'd2;
    localparam logic [2:0] FWD_T_GETS      = 3'd3;

    localparam logic [2:0] INR_T_GETS      = 3'd0;
    localparam logic [2:0] INR_T_GETX      = 3'd1;
    localparam logic [2:0] INR_T_UPGRADE   = 3'd2;
    localparam logic [2:0] INR_T_PUTX      = 3'd3;
    localparam logic [2:0] INR_T_INV_DATA  = 3'd4;
    localparam logic [2:0] INR_T_INV_ACK   = 3'd5;

    typedef struct packed {
        logic known;
        evt_e code;
    } dec_t;

    function automatic logic inner_may_hold(input logic [4:0] st);
        case (line_st_e'(st))
            ST_S, ST_E, ST_M, ST_S_IV, ST_E_IV, ST_M_IV, ST_SM_IV: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/coh_rsp_decode.sv
module coh_rsp_decode
    import coh_evt_pkg::*;
#(
    parameter int ACK_W = 4
) (
    input  logic [2:0]       typ_i,
    input  logic [ACK_W-1:0] ack_cnt_i,
    input  logic [ACK_W-1:0] pend_i,
    input  logic             peer_i,
    input  logic [4:0]       st_i,
    output dec_t             dec_o
);
    logic settled;
    assign settled = (pend_i == ack_cnt_i);

    always_comb begin
        dec_o = '{known: 1'b1, code: EV_NONE};
        case (typ_i)
            RSP_T_DATA_EXCL: dec_o.code = EV_DATA_EXCL;
            RSP_T_DATA: begin
                if (line_st_e'(st_i) == ST_IS && peer_i) dec_o.code = EV_DATA_PEER;
                else if (settled)                       dec_o.code = EV_DATA_ALL;
                else                                    dec_o.code = EV_DATA;
            end
            RSP_T_ACK:    dec_o.code = settled ? EV_ACK_ALL : EV_ACK;
            RSP_T_WB_ACK: dec_o.code = EV_WB_ACK;
            default:      dec_o.known = 1'b0;
        endcase
    end
endmodule

// File: rtl/coh_fwd_decode.sv
module coh_fwd_decode
    import coh_evt_pkg::*;
(
    input  logic [2:0] typ_i,
    input  logic       line_vld_i,
    input  logic [4:0] st_i,
    output dec_t       dec_o
);
    logic redirect;
    assign redirect = line_vld_i && inner_may_hold(st_i);

    always_comb begin
        dec_o = '{known: 1'b1, code: EV_NONE};
        case (typ_i)
            FWD_T_INV:                 dec_o.code = redirect ? EV_INR_INV_OTHER : EV_INV;
            FWD_T_GETX, FWD_T_UPGRADE: dec_o.code = redirect ? EV_INR_INV_OTHER : EV_FWD_EXCL;
            FWD_T_GETS:                dec_o.code = redirect ? EV_INR_INV_OTHER : EV_FWD_SHARED;
            default:                   dec_o.known = 1'b0;
        endcase
    end
endmodule

// File: rtl/coh_inr_decode.sv
module coh_inr_decode
    import coh_evt_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [2:0]        typ_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              line_vld_i,
    input  logic              way_free_i,
    input  logic [ADDR_W-1:0] vic_addr_i,
    input  logic              vic_vld_i,
    input  logic [4:0]        vic_st_i,
    output dec_t              dec_o,
    output logic [ADDR_W-1:0] tgt_addr_o
);
    evt_e base;
    logic is_demand;

    always_comb begin
        is_demand = 1'b1;
        base      = EV_NONE;
        case (typ_i)
            INR_T_GETS:                 base = EV_LOAD;
            INR_T_GETX, INR_T_UPGRADE:  base = EV_STORE;
            INR_T_PUTX:                 base = EV_WRITEBACK;
            default:                    is_demand = 1'b0;
        endcase
    end

    always_comb begin
        dec_o      = '{known: 1'b1, code: EV_NONE};
        tgt_addr_o = addr_i;
        if (is_demand) begin
            if (line_vld_i || way_free_i) begin
                dec_o.code = base;
            end else begin
                tgt_addr_o = vic_addr_i;
                dec_o.code = (vic_vld_i && inner_may_hold(vic_st_i)) ? EV_INR_INV_OWN : EV_EVICT;
            end
        end else begin
            case (typ_i)
                INR_T_INV_DATA: dec_o.code  = EV_INR_DATA_ACK;
                INR_T_INV_ACK:  dec_o.code  = EV_INR_ACK;
                default:        dec_o.known = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/coh_park_ctl.sv
module coh_park_ctl
    import coh_evt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NQ     = NUM_Q
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NQ-1:0]     set_i,
    input  logic [ADDR_W-1:0] set_addr_i,
    input  logic              wake_i,
    input  logic [ADDR_W-1:0] wake_addr_i,
    output logic [NQ-1:0]     parked_o
);
    for (genvar q = 0; q < NQ; q++) begin : g_slot
        logic [ADDR_W-1:0] addr_q;
        logic              hit;
        assign hit = wake_i && (wake_addr_i == addr_q);

        always_ff @(posedge clk) begin
            if (rst) begin
                parked_o[q] <= 1'b0;
                addr_q      <= '0;
            end else if (set_i[q]) begin
                parked_o[q] <= 1'b1;
                addr_q      <= set_addr_i;
            end else if (hit) begin
                parked_o[q] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/coh_event_classifier.sv
module coh_event_classifier
    import coh_evt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int ACK_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rsp_vld_i,
    input  logic [2:0]        rsp_type_i,
    input  logic [ADDR_W-1:0] rsp_addr_i,
    input  logic [ACK_W-1:0]  rsp_ack_cnt_i,
    input  logic              rsp_from_peer_i,
    input  logic [4:0]        rsp_line_state_i,
    input  logic [ACK_W-1:0]  rsp_pend_acks_i,
    input  logic              fwd_vld_i,
    input  logic [2:0]        fwd_type_i,
    input  logic [ADDR_W-1:0] fwd_addr_i,
    input  logic              fwd_line_vld_i,
    input  logic [4:0]        fwd_line_state_i,
    input  logic              inr_vld_i,
    input  logic [2:0]        inr_type_i,
    input  logic [ADDR_W-1:0] inr_addr_i,
    input  logic              inr_line_vld_i,
    input  logic              inr_way_free_i,
    input  logic [ADDR_W-1:0] vic_addr_i,
    input  logic              vic_line_vld_i,
    input  logic [4:0]        vic_line_state_i,
    input  logic              evt_stall_i,
    input  logic              wake_i,
    input  logic [ADDR_W-1:0] wake_addr_i,
    output logic              evt_vld_o,
    output logic [1:0]        evt_src_o,
    output logic [4:0]        evt_code_o,
    output logic [ADDR_W-1:0] evt_addr_o,
    output logic              rsp_deq_o,
    output logic              fwd_deq_o,
    output logic              inr_deq_o,
    output logic              err_o
);
    dec_t              rsp_dec, fwd_dec, inr_dec, sel_dec;
    logic [ADDR_W-1:0] inr_tgt, sel_addr;
    logic [NUM_Q-1:0]  parked, elig, deq, park_set;
    logic              have, accept;
    src_e              sel;

    coh_rsp_decode #(.ACK_W(ACK_W)) u_rsp (
        .typ_i(rsp_type_i), .ack_cnt_i(rsp_ack_cnt_i), .pend_i(rsp_pend_acks_i),
        .peer_i(rsp_from_peer_i), .st_i(rsp_line_state_i), .dec_o(rsp_dec)
    );

    coh_fwd_decode u_fwd (
        .typ_i(fwd_type_i), .line_vld_i(fwd_line_vld_i),
        .st_i(fwd_line_state_i), .dec_o(fwd_dec)
    );

    coh_inr_decode #(.ADDR_W(ADDR_W)) u_inr (
        .typ_i(inr_type_i), .addr_i(inr_addr_i), .line_vld_i(inr_line_vld_i),
        .way_free_i(inr_way_free_i), .vic_addr_i(vic_addr_i),
        .vic_vld_i(vic_line_vld_i), .vic_st_i(vic_line_state_i),
        .dec_o(inr_dec), .tgt_addr_o(inr_tgt)
    );

    coh_park_ctl #(.ADDR_W(ADDR_W), .NQ(NUM_Q)) u_park (
        .clk(clk), .rst(rst), .set_i(park_set), .set_addr_i(evt_addr_o),
        .wake_i(wake_i), .wake_addr_i(wake_addr_i), .parked_o(parked)
    );

    assign elig = {inr_vld_i, fwd_vld_i, rsp_vld_i} & ~parked;

    always_comb begin
        have     = |elig;
        sel      = SRC_RSP;
        sel_dec  = rsp_dec;
        sel_addr = rsp_addr_i;
        if (elig[SRC_RSP]) begin
            sel      = SRC_RSP;
            sel_dec  = rsp_dec;
            sel_addr = rsp_addr_i;
        end else if (elig[SRC_FWD]) begin
            sel      = SRC_FWD;
            sel_dec  = fwd_dec;
            sel_addr = fwd_addr_i;
        end else if (elig[SRC_INR]) begin
            sel      = SRC_INR;
            sel_dec  = inr_dec;
            sel_addr = inr_tgt;
        end
    end

    assign evt_vld_o  = have && sel_dec.known;
    assign err_o      = have && !sel_dec.known;
    assign evt_src_o  = evt_vld_o ? sel : 2'd0;
    assign evt_code_o = evt_vld_o ? sel_dec.code : EV_NONE;
    assign evt_addr_o = evt_vld_o ? sel_addr : '0;
    assign accept     = err_o || (evt_vld_o && !evt_stall_i);

    always_comb begin
        deq      = '0;
        park_set = '0;
        deq[sel]      = accept;
        park_set[sel] = evt_vld_o && evt_stall_i;
    end

    assign rsp_deq_o = deq[SRC_RSP];
    assign fwd_deq_o = deq[SRC_FWD];
    assign inr_deq_o = deq[SRC_INR];

    AST_ONE_DEQ: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_deq_o, fwd_deq_o, inr_deq_o})); // R1
    AST_RSP_FIRST: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld_i && !parked[SRC_RSP]) |-> (!fwd_deq_o && !inr_deq_o)); // R1
    AST_FWD_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        (evt_vld_o && evt_src_o == SRC_FWD && fwd_line_vld_i && inner_may_hold(fwd_line_state_i))
        |-> evt_code_o == EV_INR_INV_OTHER); // R4
    AST_VICTIM_ADDR: assert property (@(posedge clk) disable iff (rst)
        (evt_vld_o && (evt_code_o == EV_EVICT || evt_code_o == EV_INR_INV_OWN))
        |-> evt_addr_o == vic_addr_i); // R6
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        err_o |-> !evt_vld_o); // R7
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (evt_vld_o && evt_stall_i) |-> !(rsp_deq_o || fwd_deq_o || inr_deq_o)); // R8
    AST_PARK_SKIP: assert property (@(posedge clk) disable iff (rst)
        !((parked[SRC_RSP] && rsp_deq_o) || (parked[SRC_FWD] && fwd_deq_o)
          || (parked[SRC_INR] && inr_deq_o))); // R8
    AST_STALL_PARKS: assert property (@(posedge clk) disable iff (rst)
        (evt_vld_o && evt_stall_i && evt_src_o == SRC_FWD) |=> !fwd_deq_o); // R8
endmodule

// File: tb/coh_event_classifier_tb.sv
module coh_event_classifier_tb_top;
    localparam int AW = 16;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          rsp_vld = 0, rsp_peer = 0, fwd_vld = 0, fwd_lv = 0;
    logic          inr_vld = 0, inr_lv = 0, inr_free = 0, vic_lv = 0;
    logic          stall = 0, wake = 0;
    logic [2:0]    rsp_type = 0, fwd_type = 0, inr_type = 0;
    logic [AW-1:0] rsp_addr = 0, fwd_addr = 0, inr_addr = 0, vic_addr = 0, wake_addr = 0;
    logic [CW-1:0] rsp_cnt = 0, rsp_pend = 0;
    logic [4:0]    rsp_st = 0, fwd_st = 0, vic_st = 0;

    logic          evt_vld, rsp_deq, fwd_deq, inr_deq, err;
    logic [1:0]    evt_src;
    logic [4:0]    evt_code;
    logic [AW-1:0] evt_addr;

    coh_event_classifier #(.ADDR_W(AW), .ACK_W(CW)) dut_i (
        .clk(clk), .rst(rst),
        .rsp_vld_i(rsp_vld), .rsp_type_i(rsp_type), .rsp_addr_i(rsp_addr),
        .rsp_ack_cnt_i(rsp_cnt), .rsp_from_peer_i(rsp_peer),
        .rsp_line_state_i(rsp_st), .rsp_pend_acks_i(rsp_pend),
        .fwd_vld_i(fwd_vld), .fwd_type_i(fwd_type), .fwd_addr_i(fwd_addr),
        .fwd_line_vld_i(fwd_lv), .fwd_line_state_i(fwd_st),
        .inr_vld_i(inr_vld), .inr_type_i(inr_type), .inr_addr_i(inr_addr),
        .inr_line_vld_i(inr_lv), .inr_way_free_i(inr_free),
        .vic_addr_i(vic_addr), .vic_line_vld_i(vic_lv), .vic_line_state_i(vic_st),
        .evt_stall_i(stall), .wake_i(wake), .wake_addr_i(wake_addr),
        .evt_vld_o(evt_vld), .evt_src_o(evt_src), .evt_code_o(evt_code),
        .evt_addr_o(evt_addr), .rsp_deq_o(rsp_deq), .fwd_deq_o(fwd_deq),
        .inr_deq_o(inr_deq), .err_o(err)
    );

    int checks = 0;
    int errors = 0;
    logic          m_park [3];
    logic [AW-1:0] m_paddr [3];
    logic          n_park [3];
    logic [AW-1:0] n_paddr [3];

    function automatic logic held(input logic [4:0] s);
        return s == 1 || s == 3 || s == 5 || s == 12 || s == 13 || s == 14 || s == 16;
    endfunction

    // returns {known, code}
    function automatic logic [5:0] rsp_model();
        case (rsp_type)
            0: return {1'b1, 5'd12};
            1: if (rsp_st == 7 && rsp_peer) return {1'b1, 5'd13};
               else return {1'b1, (rsp_pend == rsp_cnt) ? 5'd14 : 5'd15};
            2: return {1'b1, (rsp_pend == rsp_cnt) ? 5'd16 : 5'd17};
            3: return {1'b1, 5'd18};
            default: return 6'd0;
        endcase
    endfunction

    function automatic logic [5:0] fwd_model();
        if (fwd_type > 3) return 6'd0;
        if (fwd_lv && held(fwd_st)) return {1'b1, 5'd7};
        case (fwd_type)
            0: return {1'b1, 5'd9};
            3: return {1'b1, 5'd11};
            default: return {1'b1, 5'd10};
        endcase
    endfunction

    function automatic logic [5:0] inr_model();
        case (inr_type)
            4: return {1'b1, 5'd4};
            5: return {1'b1, 5'd5};
            6, 7: return 6'd0;
            default: begin
                if (inr_lv || inr_free)
                    return {1'b1, (inr_type == 0) ? 5'd1 : (inr_type == 3) ? 5'd3 : 5'd2};
                return {1'b1, (vic_lv && held(vic_st)) ? 5'd6 : 5'd8};
            end
        endcase
    endfunction

    task automatic check(input string tag);
        logic [5:0] r [3];
        logic [AW-1:0] a [3];
        logic el [3];
        int q;
        logic e_vld, e_err, e_acc;
        logic [1:0] e_src;
        logic [4:0] e_code;
        logic [AW-1:0] e_addr;
        logic [2:0] e_deq, a_deq;
        r[0] = rsp_model(); r[1] = fwd_model(); r[2] = inr_model();
        a[0] = rsp_addr; a[1] = fwd_addr;
        a[2] = (inr_type <= 3 && !inr_lv && !inr_free) ? vic_addr : inr_addr;
        el[0] = rsp_vld && !m_park[0];
        el[1] = fwd_vld && !m_park[1];
        el[2] = inr_vld && !m_park[2];
        q = el[0] ? 0 : el[1] ? 1 : el[2] ? 2 : -1;
        e_vld = 0; e_err = 0; e_src = 0; e_code = 0; e_addr = 0; e_deq = 0;
        for (int k = 0; k < 3; k++) begin n_park[k] = m_park[k]; n_paddr[k] = m_paddr[k]; end
        for (int k = 0; k < 3; k++)
            if (wake && m_park[k] && m_paddr[k] == wake_addr) n_park[k] = 0;
        if (q >= 0) begin
            e_vld = r[q][5];
            e_err = !r[q][5];
            if (e_vld) begin e_src = 2'(q); e_code = r[q][4:0]; e_addr = a[q]; end
            e_acc = e_err || (e_vld && !stall);
            e_deq[q] = e_acc;
            if (e_vld && stall) begin n_park[q] = 1; n_paddr[q] = a[q]; end
        end
        a_deq = {inr_deq, fwd_deq, rsp_deq};
        checks++;
        if (evt_vld !== e_vld || err !== e_err || evt_src !== e_src || evt_code !== e_code
            || evt_addr !== e_addr || a_deq !== e_deq) begin
            errors++;
            $display("FAIL %s: got vld=%0b err=%0b src=%0d code=%0d addr=%h deq=%b, exp vld=%0b err=%0b src=%0d code=%0d addr=%h deq=%b",
                     tag, evt_vld, err, evt_src, evt_code, evt_addr, a_deq,
                     e_vld, e_err, e_src, e_code, e_addr, e_deq);
        end
    endtask

    task automatic step(input string tag);
        @(negedge clk);
        check(tag);
        @(posedge clk);
        #1;
        for (int k = 0; k < 3; k++) begin m_park[k] = n_park[k]; m_paddr[k] = n_paddr[k]; end
    endtask

    task automatic idle();
        rsp_vld = 0; fwd_vld = 0; inr_vld = 0; stall = 0; wake = 0;
    endtask

    task automatic randomize_inputs();
        rsp_vld  = ($urandom % 3) != 0;
        fwd_vld  = ($urandom % 2) != 0;
        inr_vld  = ($urandom % 2) != 0;
        rsp_type = (($urandom % 12) == 0) ? 3'(4 + $urandom % 4) : 3'($urandom % 4);
        fwd_type = (($urandom % 12) == 0) ? 3'(4 + $urandom % 4) : 3'($urandom % 4);
        inr_type = (($urandom % 12) == 0) ? 3'(6 + $urandom % 2) : 3'($urandom % 6);
        rsp_addr = AW'($urandom % 4);
        fwd_addr = AW'($urandom % 4);
        inr_addr = AW'($urandom % 4);
        vic_addr = AW'(4 + $urandom % 4);
        rsp_cnt  = CW'($urandom % 4);
        rsp_pend = (($urandom % 2) != 0) ? rsp_cnt : CW'($urandom % 4);
        rsp_peer = ($urandom % 2) != 0;
        rsp_st   = 5'($urandom % 17);
        fwd_st   = 5'($urandom % 17);
        vic_st   = 5'($urandom % 17);
        fwd_lv   = ($urandom % 2) != 0;
        inr_lv   = ($urandom % 3) == 0;
        inr_free = ($urandom % 3) == 0;
        vic_lv   = ($urandom % 2) != 0;
        stall    = ($urandom % 5) == 0;
        wake     = ($urandom % 4) == 0;
        wake_addr = AW'($urandom % 8);
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int k = 0; k < 3; k++) begin m_park[k] = 0; m_paddr[k] = 0; end
        repeat (3) @(posedge clk);
        #1 rst = 0;
        idle();
        step("R10 idle after reset");

        // R1 all three valid, response wins
        rsp_vld = 1; rsp_type = 3; rsp_addr = 16'h11;
        fwd_vld = 1; fwd_type = 0; fwd_addr = 16'h22; fwd_lv = 0;
        inr_vld = 1; inr_type = 0; inr_addr = 16'h33; inr_lv = 1;
        step("R1 priority");
        rsp_vld = 0; step("R1 forwarded next");

        idle(); rsp_vld = 1; rsp_type = 1; rsp_st = 7; rsp_peer = 1; rsp_cnt = 2; rsp_pend = 2;
        step("R2 peer fill");
        rsp_st = 8; step("R2 data all acks");
        rsp_pend = 3; step("R2 data pending");
        rsp_type = 0; step("R2 exclusive data");
        rsp_type = 2; rsp_pend = 3; rsp_cnt = 3; step("R3 last ack");
        rsp_cnt = 1; step("R3 ack");
        rsp_type = 3; step("R3 writeback ack");

        idle(); fwd_vld = 1; fwd_type = 3; fwd_lv = 1; fwd_st = 1; step("R4 redirect");
        fwd_lv = 0; step("R4 shared forward");
        fwd_lv = 1; fwd_st = 2; fwd_type = 2; step("R4 upgrade forward");

        idle(); inr_vld = 1; inr_type = 1; inr_lv = 1; step("R5 store hit");
        inr_type = 5; step("R5 inner ack");
        inr_type = 0; inr_lv = 0; inr_free = 0; vic_addr = 16'h77; vic_lv = 1; vic_st = 5;
        step("R6 own invalidate");
        vic_st = 6; step("R6 eviction");

        idle(); rsp_vld = 1; rsp_type = 6; stall = 1; step("R7 unknown response");

        idle(); fwd_vld = 1; fwd_type = 0; fwd_lv = 0; fwd_addr = 16'h5;
        inr_vld = 1; inr_type = 4; stall = 1; step("R8 stall forwarded");
        stall = 0; step("R8 lower queue proceeds");
        wake = 1; wake_addr = 16'h6; step("R9 non-matching wake");
        wake_addr = 16'h5; step("R9 matching wake");
        wake = 0; step("R9 released queue chosen");

        for (int i = 0; i < 3000; i++) begin
            randomize_inputs();
            step("R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule